// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a word-addressed scratchpad that is divided into 16 independent banks, and it serves a group of 16 threads. A whole group of requests is presented in one valid/ready handshake. Each thread has its own word address, its own write enable and write value, and an active bit. The block works out which bank each active request targets. It then drives the banks over the fewest cycles it can, with no bank seeing more than one address in any cycle.

When two or more active requests fall in the same bank, the block serializes them. Each cycle it grants, for every bank, the lowest-numbered thread that is still waiting on that bank. A group with no bank conflicts finishes after a single bank cycle. Once every active request has been served, the block raises a one-cycle completion pulse. Per-thread read results are valid from that pulse until the next group is accepted. The bank storage is held inside the block.

Top module: `smem_conflict_serializer`

## Requirements
- R1: A group is accepted on a clock edge where `grp_valid` and `grp_ready` are both high. `grp_ready` stays low from the edge after acceptance until the completion pulse is raised.
- R2: A word address selects bank = address mod 16 and row = address / 16. Each bank performs at most one access in any cycle.
- R3: When active requests share a bank, the lower-numbered thread is served in an earlier cycle. A read that follows a write to the same address within the group returns the written value. A read that precedes such a write returns the old value.
- R4: The number of bank cycles for a group equals the largest number of active requests that target any single bank, with a minimum of one. A stride-1 or odd-stride group therefore takes one cycle. An empty group also takes one cycle.
- R5: Inactive threads make no bank access. A write from an inactive thread leaves memory unchanged, and the read lane of an inactive thread returns zero.
- R6: `grp_done` is high for exactly one cycle per group. `rd_data` is valid while `grp_done` is high and holds until the next acceptance.
- R7: A write stores its value at its word address, and a later read of that address returns the stored value.
- R8: The read lane of an active writing thread returns zero.
- R9: After reset, `grp_ready` is 1, `grp_done` is 0 and all of `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | Group request present |
| grp_ready | output | 1 | Block is idle and can accept a group |
| thr_active | input | 16 | Per-thread active bit |
| thr_write | input | 16 | Per-thread write enable (1 = write, 0 = read) |
| thr_addr | input | 128 | Word address per thread; thread t uses bits [8t+7:8t] |
| thr_wdata | input | 512 | Write value per thread; thread t uses bits [32t+31:32t] |
| grp_done | output | 1 | One-cycle pulse that marks group completion |
| rd_data | output | 512 | Read result per thread, in the same lane layout as thr_wdata |

## Verification
The bench checks the cycle count for several strides against the worst per-bank load. It uses stride 1 and 3 for one cycle, stride 2 for two cycles, stride 16 for sixteen cycles, and a partially active stride-16 group. An arbiter that ignores conflicts would corrupt data or finish too early. One that serializes everything would be too slow on conflict-free groups. Same-address write/read pairs in one group expose a wrong service order, which would give stale or premature data. Further groups cover inactive writers that must not touch memory, an empty group that must still complete in one cycle, and the single-cycle width of the done pulse with read data held after it. Each of these would show a leak, a hang, or a repeated or lost pulse.

// File: rtl/smem_pkg.sv
package smem_pkg;
    parameter int unsigned DEF_THREADS = 16;
    parameter int unsigned DEF_BANKS   = 16;
    parameter int unsigned DEF_ADDR_W  = 8;
    parameter int unsigned DEF_DATA_W  = 32;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } smem_state_e;
endpackage

// File: rtl/smem_bank_map.sv
module smem_bank_map #(
    parameter int unsigned NT = 16,
    parameter int unsigned AW = 8,
    parameter int unsigned BW = 4
) (
    input  logic [NT-1:0][AW-1:0]    addr,
    output logic [NT-1:0][BW-1:0]    bank,
    output logic [NT-1:0][AW-BW-1:0] row
);
    for (genvar t = 0; t < NT; t++) begin : g_map
        assign bank[t] = addr[t][BW-1:0];
        assign row[t]  = addr[t][AW-1:BW];
    end
endmodule

// File: rtl/smem_grant_arb.sv
module smem_grant_arb #(
    parameter int unsigned NT = 16,
    parameter int unsigned BW = 4
) (
    input  logic [NT-1:0]         pending,
    input  logic [NT-1:0][BW-1:0] bank,
    output logic [NT-1:0]         grant
);
    always_comb begin
        for (int t = 0; t < NT; t++) begin
            grant[t] = pending[t];
            for (int u = 0; u < t; u++) begin
                if (pending[u] && (bank[u] == bank[t])) begin
                    grant[t] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/smem_bank_store.sv
module smem_bank_store #(
    parameter int unsigned NB   = 16,
    parameter int unsigned RW   = 4,
    parameter int unsigned DW   = 32,
    parameter int unsigned ROWS = 16
) (
    input  logic                  clk,
    input  logic [NB-1:0]         en,
    input  logic [NB-1:0]         we,
    input  logic [NB-1:0][RW-1:0] row,
    input  logic [NB-1:0][DW-1:0] wdata,
    output logic [NB-1:0][DW-1:0] rdata
);
    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];
        always_ff @(posedge clk) begin
            if (en[b] && we[b]) begin
                mem[row[b]] <= wdata[b];
            end
        end
        assign rdata[b] = mem[row[b]];
    end
endmodule

// File: rtl/smem_conflict_serializer.sv
module smem_conflict_serializer
    import smem_pkg::*;
#(
    parameter int unsigned NT = DEF_THREADS,
    parameter int unsigned NB = DEF_BANKS,
    parameter int unsigned AW = DEF_ADDR_W,
    parameter int unsigned DW = DEF_DATA_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grp_valid,
    output logic           grp_ready,
    input  logic [NT-1:0]  thr_active,
    input  logic [NT-1:0]  thr_write,
    input  logic [NT*AW-1:0] thr_addr,
    input  logic [NT*DW-1:0] thr_wdata,
    output logic           grp_done,
    output logic [NT*DW-1:0] rd_data
);
    localparam int unsigned BW   = $clog2(NB);
    localparam int unsigned RW   = AW - BW;
    localparam int unsigned ROWS = (1 << AW) / NB;

    typedef struct packed {
        smem_state_e           state;
        logic                  done;
        logic [NT-1:0]         pending;
        logic [NT-1:0]         active;
        logic [NT-1:0]         wr;
        logic [NT-1:0][AW-1:0] addr;
        logic [NT-1:0][DW-1:0] wdata;
        logic [NT-1:0][DW-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [NT-1:0][BW-1:0] thr_bank;
    logic [NT-1:0][RW-1:0] thr_row;
    logic [NT-1:0]         grant;
    logic [NB-1:0]         bk_en, bk_we;
    logic [NB-1:0][RW-1:0] bk_row;
    logic [NB-1:0][DW-1:0] bk_wdata, bk_rdata;
    logic                  accept;

    smem_bank_map #(.NT(NT), .AW(AW), .BW(BW)) i_map (
        .addr (r_q.addr),
        .bank (thr_bank),
        .row  (thr_row)
    );

    smem_grant_arb #(.NT(NT), .BW(BW)) i_arb (
        .pending (r_q.state == ST_BUSY ? r_q.pending : '0),
        .bank    (thr_bank),
        .grant   (grant)
    );

    smem_bank_store #(.NB(NB), .RW(RW), .DW(DW), .ROWS(ROWS)) i_store (
        .clk   (clk),
        .en    (bk_en),
        .we    (bk_we),
        .row   (bk_row),
        .wdata (bk_wdata),
        .rdata (bk_rdata)
    );

    assign grp_ready = (r_q.state == ST_IDLE);
    assign grp_done  = r_q.done;
    assign rd_data   = r_q.rdata;
    assign accept    = grp_valid && grp_ready;

    // Route each granted thread onto its bank port.
    always_comb begin
        bk_en    = '0;
        bk_we    = '0;
        bk_row   = '0;
        bk_wdata = '0;
        for (int b = 0; b < NB; b++) begin
            for (int t = 0; t < NT; t++) begin
                if (grant[t] && (thr_bank[t] == BW'(b))) begin
                    bk_en[b]    = 1'b1;
                    bk_we[b]    = r_q.wr[t];
                    bk_row[b]   = thr_row[t];
                    bk_wdata[b] = r_q.wdata[t];
                end
            end
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (accept) begin
            r_d.state   = ST_BUSY;
            r_d.pending = thr_active;
            r_d.active  = thr_active;
            r_d.wr      = thr_write;
            r_d.addr    = thr_addr;
            r_d.wdata   = thr_wdata;
            r_d.rdata   = '0;
        end else if (r_q.state == ST_BUSY) begin
            for (int t = 0; t < NT; t++) begin
                if (grant[t] && !r_q.wr[t]) begin
                    r_d.rdata[t] = bk_rdata[thr_bank[t]];
                end
            end
            r_d.pending = r_q.pending & ~grant;
            if (r_d.pending == '0) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state   <= ST_IDLE;
            r_q.done    <= 1'b0;
            r_q.pending <= '0;
            r_q.active  <= '0;
            r_q.wr      <= '0;
            r_q.addr    <= '0;
            r_q.wdata   <= '0;
            r_q.rdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R2: one access per bank per cycle
    for (genvar b = 0; b < NB; b++) begin : g_chk
        logic [NT-1:0] hit;
        always_comb begin
            for (int t = 0; t < NT; t++) hit[t] = grant[t] && (thr_bank[t] == BW'(b));
        end
        a_r2_one_per_bank: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= 1);
    end

    a_r5_no_inactive_access: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~r_q.active) == '0);

    a_r4_progress: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_BUSY && r_q.pending != '0) |=>
            ($countones(r_q.pending) < $countones($past(r_q.pending))));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |=> !grp_done);

    a_r1_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        grp_done |-> grp_ready);

    a_r6_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_ready && !accept) |=> $stable(rd_data));
endmodule

// File: tb/test_smem_conflict_serializer.sv
module test_smem_conflict_serializer;
    localparam int NT = 16;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_valid = 1'b0;
    logic grp_ready, grp_done;
    logic [NT-1:0] thr_active = '0, thr_write = '0;
    logic [NT-1:0][AW-1:0] thr_addr = '0;
    logic [NT-1:0][DW-1:0] thr_wdata = '0;
    logic [NT-1:0][DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] model [256];

    always #2.5 clk = ~clk;

    smem_conflict_serializer i_smem_conflict_serializer (
        .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
        .thr_active(thr_active), .thr_write(thr_write), .thr_addr(thr_addr),
        .thr_wdata(thr_wdata), .grp_done(grp_done), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one group, compares cycle count and every lane against the bench model.
    task automatic run_group(input string req, input logic [NT-1:0] act, input logic [NT-1:0] wr,
                             input logic [NT-1:0][AW-1:0] ad, input logic [NT-1:0][DW-1:0] wd);
        logic [NT-1:0][DW-1:0] exp_rd;
        int cnt [16];
        int exp_cyc;
        int cyc;
        logic ready_leak;
        exp_rd = '0;
        for (int b = 0; b < 16; b++) cnt[b] = 0;
        for (int t = 0; t < NT; t++) begin
            if (act[t]) begin
                cnt[ad[t] % 16]++;
                if (wr[t]) model[ad[t]] = wd[t];
                else exp_rd[t] = model[ad[t]];
            end
        end
        exp_cyc = 1;
        for (int b = 0; b < 16; b++) if (cnt[b] > exp_cyc) exp_cyc = cnt[b];

        @(negedge clk);
        thr_active = act; thr_write = wr; thr_addr = ad; thr_wdata = wd;
        grp_valid = 1'b1;
        @(negedge clk);
        grp_valid = 1'b0;
        ready_leak = grp_ready;
        cyc = 0;
        while (!grp_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            if (!grp_done && grp_ready) ready_leak = 1'b1;
        end
        check({"R1 ready low while busy ", req}, 64'(ready_leak), 64'd0);
        check({"R4 cycle count ", req}, 64'(cyc), 64'(exp_cyc));
        for (int t = 0; t < NT; t++) begin
            check({"lane data ", req}, 64'(rd_data[t]), 64'(exp_rd[t]));
        end
        @(negedge clk);
        check({"R6 done one cycle ", req}, 64'(grp_done), 64'd0);
        check({"R6 data held ", req}, 64'(rd_data == exp_rd), 64'd1);
    endtask

    task automatic t_fill;
        logic [NT-1:0][AW-1:0] ad;
        logic [NT-1:0][DW-1:0] wd;
        for (int g = 0; g < 16; g++) begin
            for (int t = 0; t < NT; t++) begin
                ad[t] = AW'(16 * g + t);
                wd[t] = 32'hA000_0000 | (16 * g + t);
            end
            run_group("R7 R8 stride1 fill", '1, '1, ad, wd);
        end
    endtask

    task automatic t_stride(input int stride, input string req);
        logic [NT-1:0][AW-1:0] ad;
        for (int t = 0; t < NT; t++) ad[t] = AW'(stride * t + 1);
        run_group(req, '1, '0, ad, '0);
    endtask

    task automatic t_partial;
        logic [NT-1:0][AW-1:0] ad;
        for (int t = 0; t < NT; t++) ad[t] = AW'(16 * t + 2);
        run_group("R5 partial active stride16", 16'h5555, '0, ad, '0);
    endtask

    task automatic t_inactive_write;
        logic [NT-1:0][AW-1:0] ad;
        logic [NT-1:0][DW-1:0] wd;
        ad = '0; wd = '0;
        ad[3] = 8'd77; wd[3] = 32'hDEAD_BEEF;
        run_group("R5 inactive write", 16'h0000, 16'h0008, ad, wd);
        ad[4] = 8'd77;
        run_group("R5 readback after inactive write", 16'h0010, 16'h0000, ad, wd);
    endtask

    task automatic t_order;
        logic [NT-1:0][AW-1:0] ad;
        logic [NT-1:0][DW-1:0] wd;
        ad = '0; wd = '0;
        ad[0] = 8'd5;  wd[0] = 32'h1111_0005;
        ad[1] = 8'd5;
        ad[2] = 8'd7;
        ad[3] = 8'd7;  wd[3] = 32'h2222_0007;
        ad[4] = 8'd21;
        run_group("R3 R8 service order", 16'h001F, 16'h0009, ad, wd);
        ad = '0;
        ad[0] = 8'd7;
        run_group("R3 R7 later read sees write", 16'h0001, 16'h0000, ad, '0);
    endtask

    task automatic t_reset;
        check("R9 ready after reset", 64'(grp_ready), 64'd1);
        check("R9 done after reset", 64'(grp_done), 64'd0);
        check("R9 rd_data after reset", 64'(rd_data == '0), 64'd1);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) model[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_stride(1, "R2 R4 R7 stride1 read");
        t_stride(3, "R4 odd stride3");
        t_stride(2, "R4 stride2");
        t_stride(16, "R2 R4 stride16");
        t_partial();
        run_group("R4 empty group", '0, '0, '0, '0);
        t_inactive_write();
        t_order();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule